// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit

This block is the execute-stage datapath of a 32-bit RISC core. Each cycle in which `op_valid` is high it takes two register operands `a` and `b` and a 5-bit operation code. On the next rising clock edge it presents one result word, which goes back to the register file. It covers wrapping add and subtract, the four logical functions AND, OR, NOR and XOR, three shifts, two rotates, and six relational compares. The compares are equal, not-equal, and signed and unsigned greater-or-equal and less-than.

Operation codes for multiply, high multiply, signed divide and unsigned divide are decoded but not executed. These codes, and every code above them, raise the `unsupported` flag in place of a result, so that the core can trap and emulate the instruction in software. The block has no state machine. There is one pipeline register stage between the operands and `result`, and it is loaded only on valid cycles. The register holds three things: the result word, a valid bit and the unsupported flag.

Top module: `alu_core`

## Requirements
- R1: After reset, `res_valid`, `unsupported` and `result` are all 0. A cycle with `op_valid` high produces `res_valid` high at the next rising edge, with the result of that operation.
- R2: Code 0 gives `a + b` and code 1 gives `a - b`, both modulo 2^32, with no overflow indication.
- R3: Code 2 gives `a & b`, code 3 gives `a | b`, code 4 gives `~(a | b)` and code 5 gives `a ^ b`.
- R4: Code 6 is a logical left shift, code 7 a logical right shift and code 8 an arithmetic right shift of `a`. The amount is `b[4:0]`, and `b[31:5]` have no effect.
- R5: Code 9 rotates `a` left and code 10 rotates `a` right, by `b[4:0]` positions; bits leaving one end re-enter at the other.
- R6: Any shift or rotate (codes 6 to 10) with `b[4:0] == 0` returns `a` unchanged.
- R7: Code 11 (equal) and code 12 (not equal) return 1 when true and 0 when false, zero-extended to 32 bits.
- R8: Code 13 (greater-or-equal) and code 14 (less-than) compare `a` and `b` as two's-complement numbers and return 1 or 0, zero-extended.
- R9: Code 15 (greater-or-equal) and code 16 (less-than) compare `a` and `b` as unsigned numbers and return 1 or 0, zero-extended.
- R10: Codes 17 to 20 (multiply, multiply-high, divide, unsigned divide) and all codes 21 to 31 set `unsupported` to 1 with `result` equal to 0. Every supported code leaves `unsupported` at 0.
- R11: A cycle with `op_valid` low gives `res_valid` 0 and `unsupported` 0 at the next edge, and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 5 | Operation code, see requirements |
| a | input | 32 | First operand; value that is shifted or rotated |
| b | input | 32 | Second operand; low five bits give the shift amount |
| res_valid | output | 1 | `result` holds a fresh operation result |
| result | output | 32 | Registered result word |
| unsupported | output | 1 | The last valid code is not implemented here |

## Verification
The hardest cases to reach are the boundaries where signed and unsigned ordering disagree. Examples are `0x80000000` against `0x7FFFFFFF`, and a shift whose amount field is zero while the upper bits of `b` are not. Both are rare under free operands. The stimulus therefore runs every one of the 32 codes against every pair drawn from twelve edge-heavy operand values, including the sign-boundary words and `0x20`, whose low five bits are zero. Each shift and rotate code then gets a full sweep of all 32 amounts, with unrelated upper bits set in `b`.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_AND  = 5'd2,
        OP_OR   = 5'd3,
        OP_NOR  = 5'd4,
        OP_XOR  = 5'd5,
        OP_SLL  = 5'd6,
        OP_SRL  = 5'd7,
        OP_SRA  = 5'd8,
        OP_ROL  = 5'd9,
        OP_ROR  = 5'd10,
        OP_EQ   = 5'd11,
        OP_NE   = 5'd12,
        OP_GES  = 5'd13,
        OP_LTS  = 5'd14,
        OP_GEU  = 5'd15,
        OP_LTU  = 5'd16,
        OP_MUL  = 5'd17,
        OP_MULH = 5'd18,
        OP_DIV  = 5'd19,
        OP_DIVU = 5'd20
    } alu_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ARITH,
        SEL_LOGIC,
        SEL_SHIFT,
        SEL_CMP
    } unit_sel_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_NOR,
        LG_XOR
    } logic_fn_e;

    typedef enum logic [1:0] {
        FILL_ZERO,
        FILL_SIGN,
        FILL_ROT
    } fill_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_NE,
        CMP_GES,
        CMP_LTS,
        CMP_GEU,
        CMP_LTU
    } cmp_kind_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [4:0] opcode,
    output unit_sel_e  sel,
    output logic       sub,
    output logic_fn_e  lfn,
    output logic       shl,
    output fill_e      fill,
    output cmp_kind_e  ckind
);
    always_comb begin
        sel   = SEL_NONE;
        sub   = 1'b0;
        lfn   = LG_AND;
        shl   = 1'b0;
        fill  = FILL_ZERO;
        ckind = CMP_EQ;
        case (opcode)
            OP_ADD:  sel = SEL_ARITH;
            OP_SUB:  begin sel = SEL_ARITH; sub = 1'b1; end
            OP_AND:  begin sel = SEL_LOGIC; lfn = LG_AND; end
            OP_OR:   begin sel = SEL_LOGIC; lfn = LG_OR;  end
            OP_NOR:  begin sel = SEL_LOGIC; lfn = LG_NOR; end
            OP_XOR:  begin sel = SEL_LOGIC; lfn = LG_XOR; end
            OP_SLL:  begin sel = SEL_SHIFT; shl = 1'b1; fill = FILL_ZERO; end
            OP_SRL:  begin sel = SEL_SHIFT; fill = FILL_ZERO; end
            OP_SRA:  begin sel = SEL_SHIFT; fill = FILL_SIGN; end
            OP_ROL:  begin sel = SEL_SHIFT; shl = 1'b1; fill = FILL_ROT; end
            OP_ROR:  begin sel = SEL_SHIFT; fill = FILL_ROT; end
            OP_EQ:   begin sel = SEL_CMP; ckind = CMP_EQ;  end
            OP_NE:   begin sel = SEL_CMP; ckind = CMP_NE;  end
            OP_GES:  begin sel = SEL_CMP; ckind = CMP_GES; end
            OP_LTS:  begin sel = SEL_CMP; ckind = CMP_LTS; end
            OP_GEU:  begin sel = SEL_CMP; ckind = CMP_GEU; end
            OP_LTU:  begin sel = SEL_CMP; ckind = CMP_LTU; end
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         eq,
    output logic         lts,
    output logic         ltu
);
    assign sum = sub ? (a - b) : (a + b);
    assign eq  = (a == b);
    assign ltu = (a < b);
    assign lts = ($signed(a) < $signed(b));
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOR:  y = ~(a | b);
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  fill_e          fill,
    output logic [W-1:0]   y
);
    logic [W-1:0] a_rev;
    logic [W-1:0] stg [0:SHW];
    logic [W-1:0] out_rev;
    logic         sign_bit;

    // left operations run through the right-going barrel on bit-reversed data
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign a_rev[i]   = a[W-1-i];
        assign out_rev[i] = stg[SHW][W-1-i];
    end

    assign sign_bit = a[W-1];
    assign stg[0]   = left ? a_rev : a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] moved;
        always_comb begin
            case (fill)
                FILL_ROT:  moved = {stg[k][D-1:0], stg[k][W-1:D]};
                FILL_SIGN: moved = {{D{sign_bit}}, stg[k][W-1:D]};
                default:   moved = {{D{1'b0}}, stg[k][W-1:D]};
            endcase
        end
        assign stg[k+1] = amt[k] ? moved : stg[k];
    end

    assign y = left ? out_rev : stg[SHW];
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [4:0]   opcode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         res_valid,
    output logic [W-1:0] result,
    output logic         unsupported
);
    localparam int SHW = $clog2(W);

    unit_sel_e    sel;
    logic         sub;
    logic_fn_e    lfn;
    logic         shl;
    fill_e        fill;
    cmp_kind_e    ckind;
    logic [W-1:0] sum_w, logic_w, shift_w, nxt;
    logic         eq, lts, ltu, cmp_bit;

    alu_decode u_dec (
        .opcode (opcode),
        .sel    (sel),
        .sub    (sub),
        .lfn    (lfn),
        .shl    (shl),
        .fill   (fill),
        .ckind  (ckind)
    );

    alu_arith #(.W(W)) u_arith (
        .a   (a),
        .b   (b),
        .sub (sub),
        .sum (sum_w),
        .eq  (eq),
        .lts (lts),
        .ltu (ltu)
    );

    alu_logic #(.W(W)) u_logic (
        .a  (a),
        .b  (b),
        .fn (lfn),
        .y  (logic_w)
    );

    alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a    (a),
        .amt  (b[SHW-1:0]),
        .left (shl),
        .fill (fill),
        .y    (shift_w)
    );

    always_comb begin
        case (ckind)
            CMP_EQ:  cmp_bit = eq;
            CMP_NE:  cmp_bit = !eq;
            CMP_GES: cmp_bit = !lts;
            CMP_LTS: cmp_bit = lts;
            CMP_GEU: cmp_bit = !ltu;
            default: cmp_bit = ltu;
        endcase
    end

    always_comb begin
        case (sel)
            SEL_ARITH: nxt = sum_w;
            SEL_LOGIC: nxt = logic_w;
            SEL_SHIFT: nxt = shift_w;
            SEL_CMP:   nxt = {{(W-1){1'b0}}, cmp_bit};
            default:   nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            unsupported <= 1'b0;
            result      <= '0;
        end else begin
            res_valid   <= op_valid;
            unsupported <= op_valid && (sel == SEL_NONE);
            if (op_valid) begin
                result <= nxt;
            end
        end
    end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [4:0]   opcode,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         res_valid,
    input logic [W-1:0] result,
    input logic         unsupported
);
    localparam int SHW = $clog2(W);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !unsupported && $stable(result)));

    assert_add_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 5'd0) |=> (result == W'($past(a) + $past(b))));

    assert_zero_amount_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode >= 5'd6 && opcode <= 5'd10 && b[SHW-1:0] == '0)
        |=> (result == $past(a)));

    assert_cmp_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode >= 5'd11 && opcode <= 5'd16) |=> (result[W-1:1] == '0));

    assert_unimpl_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode >= 5'd17) |=> (unsupported && result == '0));

    assert_impl_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode <= 5'd16) |=> !unsupported);

    assert_flag_only_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> res_valid);
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .opcode      (opcode),
    .a           (a),
    .b           (b),
    .res_valid   (res_valid),
    .result      (result),
    .unsupported (unsupported)
);

// File: tb/alu_core_test.sv
module alu_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  opcode = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        res_valid;
    logic [31:0] result;
    logic        unsupported;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu_core #(.W(32)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .opcode      (opcode),
        .a           (a),
        .b           (b),
        .res_valid   (res_valid),
        .result      (result),
        .unsupported (unsupported)
    );

    localparam logic [31:0] PATS [12] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h7FFF_FFFF,
        32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
        32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_001F, 32'h0000_0020
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] op, input logic [31:0] y);
        if (op <= 5'd1) return "R2";
        if (op <= 5'd5) return "R3";
        if (op <= 5'd10 && y[4:0] == 5'd0) return "R6";
        if (op <= 5'd8) return "R4";
        if (op <= 5'd10) return "R5";
        if (op <= 5'd12) return "R7";
        if (op <= 5'd14) return "R8";
        if (op <= 5'd16) return "R9";
        return "R10";
    endfunction

    task automatic model(input logic [4:0] op, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] r, output logic u);
        int s;
        logic [63:0] dbl;
        logic [63:0] tmp;
        s   = int'(y[4:0]);
        dbl = {x, x};
        u   = 1'b0;
        r   = '0;
        case (op)
            5'd0:  r = x + y;
            5'd1:  r = x - y;
            5'd2:  r = x & y;
            5'd3:  r = x | y;
            5'd4:  r = ~(x | y);
            5'd5:  r = x ^ y;
            5'd6:  r = x << s;
            5'd7:  r = x >> s;
            5'd8:  r = $signed(x) >>> s;
            5'd9:  begin tmp = dbl << s; r = tmp[63:32]; end
            5'd10: begin tmp = dbl >> s; r = tmp[31:0]; end
            5'd11: r = {31'd0, x == y};
            5'd12: r = {31'd0, x != y};
            5'd13: r = {31'd0, $signed(x) >= $signed(y)};
            5'd14: r = {31'd0, $signed(x) < $signed(y)};
            5'd15: r = {31'd0, x >= y};
            5'd16: r = {31'd0, x < y};
            default: begin r = '0; u = 1'b1; end
        endcase
    endtask

    // called at a falling edge; returns at the next falling edge with outputs checked
    task automatic run_op(input logic [4:0] op, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er;
        logic        eu;
        string       t;
        op_valid = 1'b1;
        opcode   = op;
        a        = x;
        b        = y;
        model(op, x, y, er, eu);
        t = tag_of(op, y);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "res_valid", {31'd0, res_valid}, 32'd1);
        chk(t, "unsupported", {31'd0, unsupported}, {31'd0, eu});
        chk(t, $sformatf("result op=%0d a=%h b=%h", op, x, y), result, er);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "res_valid after reset", {31'd0, res_valid}, 32'd0);
        chk("R1", "unsupported after reset", {31'd0, unsupported}, 32'd0);
        chk("R1", "result after reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // all codes against all operand pairs
        for (int op = 0; op < 32; op++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    run_op(5'(op), PATS[i], PATS[j]);
                end
            end
        end

        // every shift amount for each shift and rotate code, upper bits of b set (R4, R5, R6)
        for (int op = 6; op <= 10; op++) begin
            for (int s = 0; s < 32; s++) begin
                run_op(5'(op), 32'h8765_4321, 32'hABCD_E000 | 32'(s));
                run_op(5'(op), 32'h8000_0001, 32'hFFFF_FFE0 | 32'(s));
                run_op(5'(op), 32'h7FFF_FFFE, 32'h5555_5540 | 32'(s));
            end
        end

        // R11: idle cycles keep the result and clear the flags, even after an unsupported code
        run_op(5'd3, 32'hF0F0_0000, 32'h0000_0F0F);
        held = result;
        op_valid = 1'b0;
        opcode   = 5'd17;
        a        = 32'h1111_1111;
        b        = 32'h2222_2222;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "res_valid idle", {31'd0, res_valid}, 32'd0);
        chk("R11", "unsupported idle", {31'd0, unsupported}, 32'd0);
        chk("R11", "result held", result, held);
        run_op(5'd19, 32'd7, 32'd3);
        op_valid = 1'b0;
        opcode   = 5'd0;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "flag cleared idle", {31'd0, unsupported}, 32'd0);
        chk("R11", "result held after unsupported", result, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule